// File: doc/BRIEF.md
# Power-On Reset Exit Sequencer

This block is the state machine that takes a small system out of power-on reset in a fixed, staged order. It waits for the supply to pass the power-on threshold and for the low-voltage detector to report a safe regulated level. Then it starts the clock generator, turns on the system, flash and bus clocks, and releases the flash controller from reset. While the flash controller initializes, the core stays in reset and the bidirectional reset pin is driven low. During this phase the block reads an option byte once. From it, it latches the core clock divider reset value and selects between a fast and a slow clock for flash initialization.

When the flash controller reports that initialization is done, the block stops pulling the reset pin low. It does not release the core yet. It first watches the pin's sampled level through a synchronizer and waits until that level has read high for a qualifying number of cycles. This covers a slow rising edge or an external device holding the pin low. Only then does it enable the core clock, release system reset and pulse a done flag.

If the supply flag or the safe-voltage flag drops at any time, the block returns to the held state on the next cycle. The latched option values stay in place until the next option read. The analog supply, the clock generator and the flash controller are outside the block and appear only as flag inputs.

Top module: `por_exit_seq`

## Requirements
- R1: While `supply_ok` or `lvd_safe` is low, the block stays held. In that state `sys_rst`=1, `pin_drive_low`=1, `flash_rst`=1, `clkgen_en`=0, `clk_en`=0 and `core_clk_en`=0.
- R2: Once both flags are high, the stages follow one cycle apart. First `clkgen_en` rises alone. Next `clk_en` becomes all ones. Next `flash_rst` falls and `opt_rd` is high for exactly one cycle. Throughout flash initialization, `sys_rst` and `pin_drive_low` stay high.
- R3: The boot divider field is made of `opt_byte[4]` (high bit) and `opt_byte[0]` (low bit). It sets `div_sel` as follows: 00 gives 7, 01 gives 3, 10 gives 1, 11 gives 0. The new value shows from the cycle after the `opt_rd` cycle, and `div_sel` changes at no other time.
- R4: `opt_byte[1]` is the fast-init bit. `slow_flash_clk` is 1 when that bit was 0 at the option read, and 0 when it was 1. The value is latched at the same time as `div_sel`.
- R5: In the flash-initialization stage, a high `flash_done` makes `pin_drive_low` fall on the next cycle while `sys_rst` stays high.
- R6: After the pin drive is released, `sys_rst` falls and `core_clk_en` rises only once `pin_level` has passed a two-flop synchronizer and then read high for 2 consecutive cycles. If the pin is high from the cycle the drive is released, release comes on the 5th clock edge after that. A high pulse of one cycle does not release the system.
- R7: A drop of `supply_ok` or `lvd_safe` in any stage, including after release, brings back the held outputs of R1 on the next cycle.
- R8: `done` is high for exactly one cycle: the first cycle in which `sys_rst` is low.
- R9: `div_sel` and `slow_flash_clk` keep their latched values through a supply drop and the held state that follows.
- R10: After `rst_n` is asserted, the outputs are the held values of R1, with `div_sel`=7, `slow_flash_clk`=1, `opt_rd`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| supply_ok | input | 1 | Supply is above the power-on threshold |
| lvd_safe | input | 1 | Low-voltage detector reports a safe regulated level |
| opt_byte | input | 8 | Non-volatile option byte |
| flash_done | input | 1 | Flash controller has finished initialization |
| pin_level | input | 1 | Sampled level of the bidirectional reset pin |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_drive_low | output | 1 | Enable for pulling the reset pin low |
| clkgen_en | output | 1 | Clock generator enable, default mode |
| clk_en | output | 3 | Clock enables: bit 0 system, bit 1 flash, bit 2 bus |
| flash_rst | output | 1 | Flash controller reset, active high |
| opt_rd | output | 1 | One-cycle strobe for reading the option byte |
| div_sel | output | 4 | Core clock divider reset code |
| slow_flash_clk | output | 1 | Selects the slow clock for flash initialization |
| core_clk_en | output | 1 | Core clock enable |
| done | output | 1 | One-cycle pulse on system release |

## Verification
Each stage output is decoded from the registered state, so it changes one cycle after the inputs that cause it. The latched option values appear one cycle after the `opt_rd` cycle. System release comes five edges after the pin goes high: two synchronizer flops, two qualifying cycles and the state register. The bench changes inputs on falling edges and samples one falling edge per cycle. For each result, it counts exactly the number of edges given above before comparing. This applies both to the vector loop over option bytes and to the directed cases: pin held low, pin glitch, and a flag dropping in the middle of the sequence or after release.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  localparam int DIV_W = 4;

  typedef enum logic [2:0] {
    ST_HOLD  = 3'd0,
    ST_GEN   = 3'd1,
    ST_CLKS  = 3'd2,
    ST_OPT   = 3'd3,
    ST_FINIT = 3'd4,
    ST_PIN   = 3'd5,
    ST_RUN   = 3'd6
  } seq_state_t;

  // Boot field to divider reset code: a larger code means a slower core clock.
  function automatic logic [DIV_W-1:0] boot_div_code(input logic [1:0] boot_sel);
    logic [DIV_W-1:0] code;
    case (boot_sel)
      2'b00:   code = DIV_W'(7);
      2'b01:   code = DIV_W'(3);
      2'b10:   code = DIV_W'(1);
      default: code = DIV_W'(0);
    endcase
    return code;
  endfunction

endpackage

// File: rtl/pin_qualifier.sv
module pin_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_ok
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          high_cnt;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  // Count consecutive high samples of the synchronized pin, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 high_cnt <= '0;
    else if (!sync_q[SYNC_STAGES-1])            high_cnt <= '0;
    else if (high_cnt != CW'(QUAL_CYCLES))      high_cnt <= high_cnt + 1'b1;
  end

  assign pin_ok = (high_cnt == CW'(QUAL_CYCLES));

endmodule

// File: rtl/boot_opt_latch.sv
module boot_opt_latch
  import por_seq_pkg::*;
#(
  parameter int OPT_W    = 8,
  parameter int BOOT_HI  = 4,
  parameter int BOOT_LO  = 0,
  parameter int FAST_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OPT_W-1:0] opt_byte,
  output logic [DIV_W-1:0] div_sel,
  output logic             slow_flash_clk
);
  logic [1:0] boot_sel;
  logic       fast_q;

  assign boot_sel = {opt_byte[BOOT_HI], opt_byte[BOOT_LO]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sel <= boot_div_code(2'b00);
      fast_q  <= 1'b0;
    end else if (load) begin
      div_sel <= boot_div_code(boot_sel);
      fast_q  <= opt_byte[FAST_BIT];
    end
  end

  assign slow_flash_clk = ~fast_q;

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import por_seq_pkg::*;
#(
  parameter int NCLK = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            power_good,
  input  logic            flash_done,
  input  logic            pin_ok,
  output seq_state_t      state,
  output logic            sys_rst,
  output logic            pin_drive_low,
  output logic            clkgen_en,
  output logic [NCLK-1:0] clk_en,
  output logic            flash_rst,
  output logic            opt_rd,
  output logic            core_clk_en,
  output logic            release_evt,
  output logic            done
);
  seq_state_t next_state;

  always_comb begin
    next_state = state;
    if (!power_good) begin
      next_state = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD:  next_state = ST_GEN;
        ST_GEN:   next_state = ST_CLKS;
        ST_CLKS:  next_state = ST_OPT;
        ST_OPT:   next_state = ST_FINIT;
        ST_FINIT: if (flash_done) next_state = ST_PIN;
        ST_PIN:   if (pin_ok)     next_state = ST_RUN;
        ST_RUN:   next_state = ST_RUN;
        default:  next_state = ST_HOLD;
      endcase
    end
  end

  assign release_evt = power_good && (state == ST_PIN) && pin_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      done  <= 1'b0;
    end else begin
      state <= next_state;
      done  <= release_evt;
    end
  end

  always_comb begin
    sys_rst       = 1'b1;
    pin_drive_low = 1'b1;
    clkgen_en     = 1'b0;
    clk_en        = '0;
    flash_rst     = 1'b1;
    opt_rd        = 1'b0;
    core_clk_en   = 1'b0;
    case (state)
      ST_GEN: begin
        clkgen_en = 1'b1;
      end
      ST_CLKS: begin
        clkgen_en = 1'b1;
        clk_en    = '1;
      end
      ST_OPT: begin
        clkgen_en = 1'b1;
        clk_en    = '1;
        flash_rst = 1'b0;
        opt_rd    = 1'b1;
      end
      ST_FINIT: begin
        clkgen_en = 1'b1;
        clk_en    = '1;
        flash_rst = 1'b0;
      end
      ST_PIN: begin
        clkgen_en     = 1'b1;
        clk_en        = '1;
        flash_rst     = 1'b0;
        pin_drive_low = 1'b0;
      end
      ST_RUN: begin
        clkgen_en     = 1'b1;
        clk_en        = '1;
        flash_rst     = 1'b0;
        pin_drive_low = 1'b0;
        sys_rst       = 1'b0;
        core_clk_en   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/por_exit_seq.sv
module por_exit_seq
  import por_seq_pkg::*;
#(
  parameter int OPT_W       = 8,
  parameter int NCLK        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             lvd_safe,
  input  logic [OPT_W-1:0] opt_byte,
  input  logic             flash_done,
  input  logic             pin_level,
  output logic             sys_rst,
  output logic             pin_drive_low,
  output logic             clkgen_en,
  output logic [NCLK-1:0]  clk_en,
  output logic             flash_rst,
  output logic             opt_rd,
  output logic [DIV_W-1:0] div_sel,
  output logic             slow_flash_clk,
  output logic             core_clk_en,
  output logic             done
);
  logic       power_good;
  logic       pin_ok;
  logic       release_evt;
  seq_state_t state;

  assign power_good = supply_ok & lvd_safe;

  pin_qualifier #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_raw (pin_level),
    .pin_ok  (pin_ok)
  );

  boot_opt_latch #(
    .OPT_W    (OPT_W),
    .BOOT_HI  (4),
    .BOOT_LO  (0),
    .FAST_BIT (1)
  ) u_opt (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (opt_rd),
    .opt_byte       (opt_byte),
    .div_sel        (div_sel),
    .slow_flash_clk (slow_flash_clk)
  );

  seq_fsm #(
    .NCLK (NCLK)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_good    (power_good),
    .flash_done    (flash_done),
    .pin_ok        (pin_ok),
    .state         (state),
    .sys_rst       (sys_rst),
    .pin_drive_low (pin_drive_low),
    .clkgen_en     (clkgen_en),
    .clk_en        (clk_en),
    .flash_rst     (flash_rst),
    .opt_rd        (opt_rd),
    .core_clk_en   (core_clk_en),
    .release_evt   (release_evt),
    .done          (done)
  );

endmodule

// File: rtl/por_exit_seq_chk.sv
module por_exit_seq_chk #(
  parameter int NCLK  = 3,
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             lvd_safe,
  input logic             pin_ok,
  input logic             sys_rst,
  input logic             pin_drive_low,
  input logic             clkgen_en,
  input logic [NCLK-1:0]  clk_en,
  input logic             flash_rst,
  input logic             opt_rd,
  input logic [DIV_W-1:0] div_sel,
  input logic             core_clk_en,
  input logic             done
);
  // R7: a flag drop restores the held outputs on the next cycle
  a_r7_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(supply_ok && lvd_safe) |=> (sys_rst && pin_drive_low && flash_rst &&
                                  !clkgen_en && clk_en == '0 && !core_clk_en));

  // R2: flash leaves reset only with every clock running
  a_r2_clocks_before_flash: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_rst |-> (clkgen_en && clk_en == '1));

  // R2: the core stays in reset while the pin is still driven
  a_r2_core_held_with_pin: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_low |-> sys_rst);

  // R2: the option read strobe lasts one cycle
  a_r2_opt_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    opt_rd |=> !opt_rd);

  // R6: release follows a qualified high pin
  a_r6_release_after_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> $past(pin_ok));

  // R6: core clock runs exactly when out of reset
  a_r6_core_clk_match: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en == !sys_rst);

  // R8: done is a single-cycle pulse inside release
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sys_rst && $fell(sys_rst)));

  // R3: divider code only moves right after a read strobe
  a_r3_div_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sel) |-> $past(opt_rd));

  // R3: divider code is always one of the four legal values
  a_r3_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == DIV_W'(7) || div_sel == DIV_W'(3) ||
     div_sel == DIV_W'(1) || div_sel == DIV_W'(0)));

endmodule

bind por_exit_seq por_exit_seq_chk #(
  .NCLK  (NCLK),
  .DIV_W (por_seq_pkg::DIV_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_ok     (supply_ok),
  .lvd_safe      (lvd_safe),
  .pin_ok        (pin_ok),
  .sys_rst       (sys_rst),
  .pin_drive_low (pin_drive_low),
  .clkgen_en     (clkgen_en),
  .clk_en        (clk_en),
  .flash_rst     (flash_rst),
  .opt_rd        (opt_rd),
  .div_sel       (div_sel),
  .core_clk_en   (core_clk_en),
  .done          (done)
);

// File: tb/sim_por_exit_seq.sv
`timescale 1ns/1ps
module sim_por_exit_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       lvd_safe;
  logic [7:0] opt_byte;
  logic       flash_done;
  logic       ext_low;
  logic       pin_level;
  logic       sys_rst, pin_drive_low, clkgen_en, flash_rst, opt_rd;
  logic [2:0] clk_en;
  logic [3:0] div_sel;
  logic       slow_flash_clk, core_clk_en, done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // Open-drain pin: low when the block or an external device pulls it.
  assign pin_level = ~pin_drive_low & ~ext_low;

  por_exit_seq u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lvd_safe(lvd_safe),
    .opt_byte(opt_byte), .flash_done(flash_done), .pin_level(pin_level),
    .sys_rst(sys_rst), .pin_drive_low(pin_drive_low), .clkgen_en(clkgen_en),
    .clk_en(clk_en), .flash_rst(flash_rst), .opt_rd(opt_rd), .div_sel(div_sel),
    .slow_flash_clk(slow_flash_clk), .core_clk_en(core_clk_en), .done(done)
  );

  typedef struct packed {
    logic [7:0] opt;
    logic [3:0] div;
    logic       slow;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{opt: 8'h00, div: 4'd7, slow: 1'b1},
    '{opt: 8'h02, div: 4'd7, slow: 1'b0},
    '{opt: 8'h01, div: 4'd3, slow: 1'b1},
    '{opt: 8'h13, div: 4'd0, slow: 1'b0},
    '{opt: 8'h10, div: 4'd1, slow: 1'b1},
    '{opt: 8'hEC, div: 4'd7, slow: 1'b1},
    '{opt: 8'h03, div: 4'd3, slow: 1'b0},
    '{opt: 8'hFF, div: 4'd0, slow: 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_held(input string req);
    chk(req, "sys_rst", sys_rst, 1);
    chk(req, "pin_drive_low", pin_drive_low, 1);
    chk(req, "flash_rst", flash_rst, 1);
    chk(req, "clkgen_en", clkgen_en, 0);
    chk(req, "clk_en", clk_en, 0);
    chk(req, "core_clk_en", core_clk_en, 0);
  endtask

  // From the held state with flags low, run up to the flash-init stage.
  task automatic to_finit(input logic [7:0] opt, input logic [3:0] ediv, input logic eslow);
    opt_byte  = opt;
    supply_ok = 1'b1;
    lvd_safe  = 1'b1;
    cyc();
    chk("R2", "gen stage clkgen_en", clkgen_en, 1);
    chk("R2", "gen stage clk_en", clk_en, 0);
    chk("R2", "gen stage flash_rst", flash_rst, 1);
    cyc();
    chk("R2", "clock stage clk_en", clk_en, 7);
    chk("R2", "clock stage flash_rst", flash_rst, 1);
    cyc();
    chk("R2", "opt stage flash_rst", flash_rst, 0);
    chk("R2", "opt stage opt_rd", opt_rd, 1);
    chk("R2", "opt stage sys_rst", sys_rst, 1);
    cyc();
    chk("R2", "opt_rd single", opt_rd, 0);
    chk("R2", "finit pin_drive_low", pin_drive_low, 1);
    chk("R3", "div_sel", div_sel, ediv);
    chk("R4", "slow_flash_clk", slow_flash_clk, eslow);
  endtask

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; lvd_safe = 1'b0;
    opt_byte = 8'h00; flash_done = 1'b0; ext_low = 1'b0;
    repeat (3) cyc();
    chk_held("R10");
    chk("R10", "div_sel", div_sel, 7);
    chk("R10", "slow_flash_clk", slow_flash_clk, 1);
    chk("R10", "opt_rd", opt_rd, 0);
    chk("R10", "done", done, 0);
    rst_n = 1'b1;

    // R1: supply good but voltage not yet safe, and the reverse
    supply_ok = 1'b1;
    repeat (5) begin cyc(); chk_held("R1"); end
    supply_ok = 1'b0; lvd_safe = 1'b1;
    repeat (3) begin cyc(); chk_held("R1"); end
    lvd_safe = 1'b0;
    cyc();

    // Vector table: full sequence per option byte
    for (int i = 0; i < 8; i++) begin
      to_finit(VECS[i].opt, VECS[i].div, VECS[i].slow);
      repeat (2) begin
        cyc();
        chk("R5", "waiting for flash pin_drive_low", pin_drive_low, 1);
      end
      flash_done = 1'b1;
      cyc();
      chk("R5", "pin_drive_low after flash_done", pin_drive_low, 0);
      chk("R5", "sys_rst after flash_done", sys_rst, 1);
      flash_done = 1'b0;
      for (int k = 0; k < 4; k++) begin
        cyc();
        chk("R6", "sys_rst during qualification", sys_rst, 1);
      end
      cyc();
      chk("R6", "sys_rst released", sys_rst, 0);
      chk("R6", "core_clk_en", core_clk_en, 1);
      chk("R8", "done pulse", done, 1);
      cyc();
      chk("R8", "done cleared", done, 0);
      chk("R8", "still released", sys_rst, 0);
      opt_byte = ~VECS[i].opt;
      supply_ok = 1'b0;
      cyc();
      chk_held("R7");
      chk("R9", "div_sel kept", div_sel, VECS[i].div);
      chk("R9", "slow kept", slow_flash_clk, VECS[i].slow);
      cyc();
    end

    // R6: pin held low externally, then a one-cycle glitch, then release
    ext_low = 1'b1;
    to_finit(8'h11, 4'd0, 1'b1);
    flash_done = 1'b1;
    cyc();
    flash_done = 1'b0;
    chk("R5", "drive off with pin held", pin_drive_low, 0);
    repeat (8) begin cyc(); chk("R6", "held by external low", sys_rst, 1); end
    ext_low = 1'b0;
    cyc();
    ext_low = 1'b1;
    repeat (8) begin cyc(); chk("R6", "glitch ignored", sys_rst, 1); end
    ext_low = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk("R6", "qualifying after external release", sys_rst, 1);
    end
    cyc();
    chk("R6", "released after external release", sys_rst, 0);
    chk("R8", "done on late release", done, 1);

    // R7: voltage drop in the middle of flash initialization
    lvd_safe = 1'b0;
    cyc();
    lvd_safe = 1'b0;
    cyc();
    to_finit(8'h02, 4'd7, 1'b0);
    lvd_safe = 1'b0;
    cyc();
    chk_held("R7");
    chk("R9", "div after mid drop", div_sel, 7);
    flash_done = 1'b1;
    repeat (3) begin cyc(); chk_held("R1"); end
    flash_done = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule